// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Wake

This block sits next to a small 8-bit CPU and decides which interrupt the core takes next. It watches up to five maskable sources and one non-maskable trap. Each maskable source has a two-bit software level set by firmware and a fixed position that settles ties. The controller holds the CPU's current level. A source is taken only when its level is strictly above that level. On each grant it pulses an acknowledge with a vector index, pushes the old level onto a short stack and loads a new level. Returning from the handler pops the stack.

Two policies are selectable. In concurrent mode a granted handler runs with the level forced to the maximum, so no maskable request can preempt it. In nested mode the level becomes the granted source's level, so only a strictly higher level can preempt. The controller also tracks two CPU sleep states. A light sleep ends on any serviceable request. A deep sleep ends only on a request from a source marked as deep-wake capable. After a deep sleep the first grant goes to a deep-wake capable source. Each peripheral can drop its pending request with a two-step clear: a status access followed by a data access.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, ackValid is 0, curLevel is 3 (all maskable sources blocked), sleeping is 0, wakeUp is 0 and no request is pending.
- R2: A pending maskable source is granted only if its two-bit level is strictly greater than curLevel. A source at level 0 is never granted.
- R3: Among grantable sources the highest level wins. On equal levels the lower source index wins, so source 0 ranks highest and source 4 lowest. vecIdx carries the source index 0 to 4; the trap uses vecIdx 5.
- R4: With nestedMode=0, a maskable grant loads curLevel with 3, and no further maskable grant happens until a return lowers the level.
- R5: With nestedMode=1, a maskable grant loads curLevel with the source's level, and a pending source with a strictly higher level is then granted without a return.
- R6: Each grant pushes the previous curLevel onto a 4-entry stack, and retInt pops it back into curLevel. A fifth push without a pop overwrites the oldest entry. A pop on an empty stack leaves curLevel unchanged.
- R7: enableAll sets curLevel to 0 and maskAll sets it to 3. When both occur together, maskAll wins. A grant or a return in the same cycle takes precedence over both.
- R8: A trap request is granted at any curLevel and ahead of every maskable source, with vecIdx 5, and it loads curLevel with 3.
- R9: A one-cycle request pulse stays pending until granted, and each pulse produces exactly one grant.
- R10: A pulse on clrStatus followed, in a later cycle, by a pulse on clrData for the same source drops that source's pending request. clrData on its own has no effect.
- R11: enterWait puts the controller to sleep (sleeping=1). While asleep, no grant is made. Any grantable request or a trap ends the sleep with a one-cycle wakeUp pulse and is then granted.
- R12: enterHalt puts the controller into deep sleep. Only a grantable request from a source with its haltCapable bit set, or a trap, ends it. Other requests leave sleeping at 1.
- R13: The first maskable grant after a deep sleep goes to the winner among deep-wake capable sources, even when a higher non-capable request is pending. That request is handled right after, by normal arbitration.
- R14: ackValid is a one-cycle pulse per grant, and vecIdx is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 5 | One-cycle request pulse per maskable source |
| srcLevel | input | 10 | Two-bit software level per source, source i at bits 2i+1:2i |
| haltCapable | input | 5 | Source may end a deep sleep |
| clrStatus | input | 5 | First step of the pending clear, per source |
| clrData | input | 5 | Second step of the pending clear, per source |
| trapReq | input | 1 | Non-maskable trap request pulse |
| nestedMode | input | 1 | 1 selects nested policy, 0 concurrent |
| retInt | input | 1 | Return from handler, pops the level stack |
| enableAll | input | 1 | Set current level to 0 |
| maskAll | input | 1 | Set current level to 3 |
| enterWait | input | 1 | Enter light sleep |
| enterHalt | input | 1 | Enter deep sleep |
| ackValid | output | 1 | Grant pulse |
| vecIdx | output | 3 | Granted vector, valid with ackValid |
| curLevel | output | 2 | Current CPU level |
| wakeUp | output | 1 | One-cycle pulse when a sleep ends |
| sleeping | output | 1 | Controller is in either sleep state |

## Verification
The bench targets ties between equal levels: a design with the tie order reversed would grant source 3 before source 1. It targets a request whose level only equals the current level in nested mode: a `>=` compare would preempt where it must not. It overflows the level stack and then drains it: a stack that drops the newest entry instead of the oldest would return the wrong levels. It wakes from deep sleep with a higher non-capable request already pending: a design without the wake filter would grant that request first, and one with the filter stuck on would never grant it. It also checks that clrData alone leaves a request pending, and that a full clear sequence removes it before it is granted.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W = 2;
  localparam int VEC_W = 3;

  typedef logic [LVL_W-1:0] level_t;
  typedef logic [VEC_W-1:0] vec_t;

  localparam level_t LVL_MAX = '1;
  localparam level_t LVL_MIN = '0;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_WAIT = 2'd1,
    PWR_HALT = 2'd2
  } pwr_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic   grant;       // take one request this cycle
    logic   grantTrap;   // the taken request is the trap
    vec_t   grantIdx;    // source index of the taken request
    level_t grantLevel;  // level loaded on grant
    logic   popLevel;    // return from handler
    logic   forceLow;    // open all levels
    logic   forceHigh;   // block all maskable levels
  } path_ctl_t;
endpackage

// File: rtl/prio_irq_path.sv
module prio_irq_path
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 5,
  parameter int STACK_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               trapReq,
  input  logic [NUM_SRC-1:0] clrStatus,
  input  logic [NUM_SRC-1:0] clrData,
  input  path_ctl_t          ctl,
  output logic [NUM_SRC-1:0] pending,
  output logic               trapPending,
  output level_t             curLevel
);
  localparam int PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(STACK_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STACK_DEPTH);

  // per-source pending latch and clear-sequence arming
  logic [NUM_SRC-1:0] clrArmed;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic takenHere;
    assign takenHere = ctl.grant && !ctl.grantTrap && (ctl.grantIdx == vec_t'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pending[i]  <= 1'b0;
        clrArmed[i] <= 1'b0;
      end else begin
        if (clrStatus[i])    clrArmed[i] <= 1'b1;
        else if (clrData[i]) clrArmed[i] <= 1'b0;

        if (srcReq[i])                                   pending[i] <= 1'b1;
        else if (takenHere || (clrArmed[i] && clrData[i])) pending[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               trapPending <= 1'b0;
    else if (trapReq)        trapPending <= 1'b1;
    else if (ctl.grant && ctl.grantTrap) trapPending <= 1'b0;
  end

  // level register with a circular save stack
  level_t           stackMem [STACK_DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] ptrInc;
  logic [PTR_W-1:0] ptrDec;
  logic [CNT_W-1:0] fill;

  assign ptrInc = (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
  assign ptrDec = (wrPtr == '0) ? PTR_LAST : wrPtr - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLevel <= LVL_MAX;
      wrPtr    <= '0;
      fill     <= '0;
      for (int k = 0; k < STACK_DEPTH; k++) stackMem[k] <= LVL_MIN;
    end else if (ctl.grant) begin
      stackMem[wrPtr] <= curLevel;
      wrPtr           <= ptrInc;
      if (fill != CNT_FULL) fill <= fill + 1'b1;
      curLevel        <= ctl.grantLevel;
    end else if (ctl.popLevel) begin
      if (fill != '0) begin
        curLevel <= stackMem[ptrDec];
        wrPtr    <= ptrDec;
        fill     <= fill - 1'b1;
      end
    end else if (ctl.forceHigh) begin
      curLevel <= LVL_MAX;
    end else if (ctl.forceLow) begin
      curLevel <= LVL_MIN;
    end
  end
endmodule

// File: rtl/prio_irq_fsm.sv
module prio_irq_fsm
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       pending,
  input  logic                     trapPending,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  logic [NUM_SRC-1:0]       haltCapable,
  input  level_t                   curLevel,
  input  logic                     nestedMode,
  input  logic                     retInt,
  input  logic                     enableAll,
  input  logic                     maskAll,
  input  logic                     enterWait,
  input  logic                     enterHalt,
  output path_ctl_t                ctl,
  output logic                     ackValid,
  output vec_t                     vecIdx,
  output logic                     wakeUp,
  output logic                     sleeping
);
  localparam vec_t TRAP_VEC = vec_t'(NUM_SRC);

  pwr_e               pwrState;
  logic               haltFirst;
  level_t             lvlOf [NUM_SRC];
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] haltEligible;
  logic [NUM_SRC-1:0] candMask;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign lvlOf[i]        = srcLevel[i*LVL_W +: LVL_W];
    assign eligible[i]     = pending[i] && (lvlOf[i] > curLevel);
    assign haltEligible[i] = eligible[i] && haltCapable[i];
  end

  // after a deep sleep restrict to capable sources while any is grantable
  assign candMask = (haltFirst && (|haltEligible)) ? haltEligible : eligible;

  logic   found;
  vec_t   bestIdx;
  level_t bestLvl;

  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestLvl = '0;
    // scan from lowest rank upward so lower indices win ties
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (candMask[i] && (!found || (lvlOf[i] >= bestLvl))) begin
        found   = 1'b1;
        bestIdx = vec_t'(i);
        bestLvl = lvlOf[i];
      end
    end
  end

  logic doGrant;
  assign doGrant = (pwrState == PWR_RUN) && (trapPending || found);

  always_comb begin
    ctl            = '0;
    ctl.grant      = doGrant;
    ctl.grantTrap  = trapPending;
    ctl.grantIdx   = trapPending ? TRAP_VEC : bestIdx;
    ctl.grantLevel = (trapPending || !nestedMode) ? LVL_MAX : bestLvl;
    ctl.popLevel   = retInt;
    ctl.forceLow   = enableAll;
    ctl.forceHigh  = maskAll;
  end

  logic waitWake;
  logic haltWake;
  assign waitWake = trapPending || (|eligible);
  assign haltWake = trapPending || (|haltEligible);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrState  <= PWR_RUN;
      haltFirst <= 1'b0;
      wakeUp    <= 1'b0;
      ackValid  <= 1'b0;
      vecIdx    <= '0;
    end else begin
      wakeUp   <= 1'b0;
      ackValid <= doGrant;
      vecIdx   <= doGrant ? ctl.grantIdx : '0;
      unique case (pwrState)
        PWR_RUN: begin
          if (doGrant)        haltFirst <= 1'b0;
          if (enterHalt)      pwrState  <= PWR_HALT;
          else if (enterWait) pwrState  <= PWR_WAIT;
        end
        PWR_WAIT: begin
          if (waitWake) begin
            pwrState <= PWR_RUN;
            wakeUp   <= 1'b1;
          end
        end
        PWR_HALT: begin
          if (haltWake) begin
            pwrState  <= PWR_RUN;
            wakeUp    <= 1'b1;
            haltFirst <= 1'b1;
          end
        end
        default: pwrState <= PWR_RUN;
      endcase
    end
  end

  assign sleeping = (pwrState != PWR_RUN);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 5,
  parameter int STACK_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       srcReq,
  input  logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input  logic [NUM_SRC-1:0]       haltCapable,
  input  logic [NUM_SRC-1:0]       clrStatus,
  input  logic [NUM_SRC-1:0]       clrData,
  input  logic                     trapReq,
  input  logic                     nestedMode,
  input  logic                     retInt,
  input  logic                     enableAll,
  input  logic                     maskAll,
  input  logic                     enterWait,
  input  logic                     enterHalt,
  output logic                     ackValid,
  output logic [VEC_W-1:0]         vecIdx,
  output logic [LVL_W-1:0]         curLevel,
  output logic                     wakeUp,
  output logic                     sleeping
);
  path_ctl_t          ctl;
  logic [NUM_SRC-1:0] pending;
  logic               trapPending;

  prio_irq_path #(.NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .srcReq      (srcReq),
    .trapReq     (trapReq),
    .clrStatus   (clrStatus),
    .clrData     (clrData),
    .ctl         (ctl),
    .pending     (pending),
    .trapPending (trapPending),
    .curLevel    (curLevel)
  );

  prio_irq_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .pending     (pending),
    .trapPending (trapPending),
    .srcLevel    (srcLevel),
    .haltCapable (haltCapable),
    .curLevel    (curLevel),
    .nestedMode  (nestedMode),
    .retInt      (retInt),
    .enableAll   (enableAll),
    .maskAll     (maskAll),
    .enterWait   (enterWait),
    .enterHalt   (enterHalt),
    .ctl         (ctl),
    .ackValid    (ackValid),
    .vecIdx      (vecIdx),
    .wakeUp      (wakeUp),
    .sleeping    (sleeping)
  );
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_SRC*LVL_W-1:0] srcLevel,
  input logic                     nestedMode,
  input logic                     retInt,
  input logic                     enableAll,
  input logic                     maskAll,
  input logic                     ackValid,
  input logic [VEC_W-1:0]         vecIdx,
  input logic [LVL_W-1:0]         curLevel,
  input logic                     wakeUp,
  input logic                     sleeping
);
  logic [NUM_SRC*LVL_W-1:0] prevSrcLvl;
  level_t prevCur;
  logic   prevNested, prevSleep, prevEn, prevMask, prevRet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSrcLvl <= '0;
      prevCur    <= LVL_MAX;
      prevNested <= 1'b0;
      prevSleep  <= 1'b0;
      prevEn     <= 1'b0;
      prevMask   <= 1'b0;
      prevRet    <= 1'b0;
    end else begin
      prevSrcLvl <= srcLevel;
      prevCur    <= curLevel;
      prevNested <= nestedMode;
      prevSleep  <= sleeping;
      prevEn     <= enableAll;
      prevMask   <= maskAll;
      prevRet    <= retInt;
    end
  end

  function automatic level_t levelAt(input logic [NUM_SRC*LVL_W-1:0] lv, input vec_t idx);
    level_t r = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (idx == vec_t'(i)) r = lv[i*LVL_W +: LVL_W];
    return r;
  endfunction

  logic ackMaskable;
  assign ackMaskable = ackValid && (vecIdx < vec_t'(NUM_SRC));

  p_level_above_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackMaskable |-> (levelAt(prevSrcLvl, vecIdx) > prevCur));

  p_vec_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (vecIdx <= vec_t'(NUM_SRC)));

  p_conc_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ackMaskable && !prevNested) |-> (curLevel == LVL_MAX));

  p_trap_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && (vecIdx == vec_t'(NUM_SRC))) |-> (curLevel == LVL_MAX));

  p_enable_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (prevEn && !prevMask && !prevRet && !ackValid) |-> (curLevel == LVL_MIN));

  p_no_ack_asleep_r11: assert property (@(posedge clk) disable iff (!rstN)
    prevSleep |-> !ackValid);

  p_wake_runs_r11: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> !sleeping);
endmodule

bind prio_irq_ctrl prio_irq_checker #(.NUM_SRC(NUM_SRC)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .srcLevel   (srcLevel),
  .nestedMode (nestedMode),
  .retInt     (retInt),
  .enableAll  (enableAll),
  .maskAll    (maskAll),
  .ackValid   (ackValid),
  .vecIdx     (vecIdx),
  .curLevel   (curLevel),
  .wakeUp     (wakeUp),
  .sleeping   (sleeping)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NSRC = 5;
  localparam int WD_CYCLES = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0]   srcReq = '0;
  logic [NSRC*2-1:0] srcLevel = '0;
  logic [NSRC-1:0]   haltCapable = '0;
  logic [NSRC-1:0]   clrStatus = '0;
  logic [NSRC-1:0]   clrData = '0;
  logic trapReq = 1'b0, nestedMode = 1'b0, retInt = 1'b0;
  logic enableAll = 1'b0, maskAll = 1'b0, enterWait = 1'b0, enterHalt = 1'b0;
  logic ackValid, wakeUp, sleeping;
  logic [2:0] vecIdx;
  logic [1:0] curLevel;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcLevel(srcLevel),
    .haltCapable(haltCapable), .clrStatus(clrStatus), .clrData(clrData),
    .trapReq(trapReq), .nestedMode(nestedMode), .retInt(retInt),
    .enableAll(enableAll), .maskAll(maskAll), .enterWait(enterWait),
    .enterHalt(enterHalt), .ackValid(ackValid), .vecIdx(vecIdx),
    .curLevel(curLevel), .wakeUp(wakeUp), .sleeping(sleeping)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic applyReset();
    rstN = 1'b0; srcReq = '0; srcLevel = '0; haltCapable = '0;
    clrStatus = '0; clrData = '0; trapReq = 0; nestedMode = 0; retInt = 0;
    enableAll = 0; maskAll = 0; enterWait = 0; enterHalt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setLvl(input int src, input int lvl);
    srcLevel[src*2 +: 2] = 2'(lvl);
  endtask

  task automatic pulseReq(input logic [NSRC-1:0] m);
    srcReq = m; @(negedge clk); srcReq = '0;
  endtask
  task automatic pulseTrap();   trapReq = 1;   @(negedge clk); trapReq = 0;   endtask
  task automatic pulseRet();    retInt = 1;    @(negedge clk); retInt = 0;    endtask
  task automatic pulseEnAll();  enableAll = 1; @(negedge clk); enableAll = 0; endtask
  task automatic pulseMaskAll();maskAll = 1;   @(negedge clk); maskAll = 0;   endtask
  task automatic pulseWait();   enterWait = 1; @(negedge clk); enterWait = 0; endtask
  task automatic pulseHalt();   enterHalt = 1; @(negedge clk); enterHalt = 0; endtask
  task automatic pulseClrSt(input logic [NSRC-1:0] m);
    clrStatus = m; @(negedge clk); clrStatus = '0;
  endtask
  task automatic pulseClrDat(input logic [NSRC-1:0] m);
    clrData = m; @(negedge clk); clrData = '0;
  endtask

  task automatic expectAck(input string tag, input int expVec, input int maxCyc);
    bit got = 0;
    int vec = -1;
    for (int c = 0; c < maxCyc && !got; c++) begin
      @(negedge clk);
      if (ackValid) begin got = 1; vec = int'(vecIdx); end
    end
    check({tag, " ack seen"}, int'(got), 1);
    check({tag, " vector"}, vec, expVec);
  endtask

  task automatic expectNoAck(input string tag, input int cycles);
    bit seen = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (ackValid) seen = 1;
    end
    check({tag, " no ack"}, int'(seen), 0);
  endtask

  // R1 reset values, R2 level gate, R9 latch held while blocked
  task automatic t_reset_and_gate();
    applyReset();
    @(negedge clk);
    check("R1 ackValid", int'(ackValid), 0);
    check("R1 curLevel", int'(curLevel), 3);
    check("R1 sleeping", int'(sleeping), 0);
    check("R1 wakeUp", int'(wakeUp), 0);
    expectNoAck("R1 nothing pending", 3);
    setLvl(1, 1); setLvl(2, 0);
    pulseReq(5'b00110);
    expectNoAck("R2 blocked at level 3", 4);
    nestedMode = 1;
    pulseEnAll();
    expectAck("R9 held request", 1, 4);
    check("R5 level after grant", int'(curLevel), 1);
    pulseRet();
    check("R6 pop to 0", int'(curLevel), 0);
    expectNoAck("R2 level-0 source", 5);
  endtask

  // R3 ordering, R4 concurrent level
  task automatic t_priority();
    applyReset();
    pulseEnAll();
    setLvl(0, 1); setLvl(1, 2); setLvl(3, 2);
    pulseReq(5'b01011);
    expectAck("R3 first", 1, 4);
    check("R4 level 3 after grant", int'(curLevel), 3);
    expectNoAck("R4 no preempt", 3);
    pulseRet();
    expectAck("R3 second tie", 3, 4);
    pulseRet();
    expectAck("R3 third", 0, 4);
  endtask

  // R4 concurrent blocking of a level-3 request
  task automatic t_concurrent();
    applyReset();
    pulseEnAll();
    setLvl(2, 1); setLvl(0, 3);
    pulseReq(5'b00100);
    expectAck("R4 low grant", 2, 4);
    pulseReq(5'b00001);
    expectNoAck("R4 level-3 waits", 5);
    pulseRet();
    expectAck("R4 after return", 0, 4);
  endtask

  // R5 nested preemption
  task automatic t_nested();
    applyReset();
    nestedMode = 1;
    pulseEnAll();
    setLvl(2, 1); setLvl(3, 2); setLvl(4, 2);
    pulseReq(5'b00100);
    expectAck("R5 first", 2, 4);
    check("R5 level 1", int'(curLevel), 1);
    pulseReq(5'b01000);
    expectAck("R5 preempt", 3, 4);
    check("R5 level 2", int'(curLevel), 2);
    pulseReq(5'b10000);
    expectNoAck("R5 equal level", 4);
    pulseRet();
    expectAck("R5 after return", 4, 4);
    check("R5 level back 2", int'(curLevel), 2);
  endtask

  // R6 stack depth, overflow and empty pop
  task automatic t_stack();
    applyReset();
    pulseRet();
    check("R6 empty pop keeps 3", int'(curLevel), 3);
    nestedMode = 1;
    pulseEnAll();
    setLvl(0, 1); setLvl(1, 2); setLvl(2, 3);
    pulseReq(5'b00001); expectAck("R6 push0", 0, 4);
    pulseReq(5'b00010); expectAck("R6 push1", 1, 4);
    pulseReq(5'b00100); expectAck("R6 push2", 2, 4);
    pulseTrap();        expectAck("R6 push3", 5, 4);
    pulseTrap();        expectAck("R6 push4", 5, 4);
    pulseRet(); check("R6 pop a", int'(curLevel), 3);
    pulseRet(); check("R6 pop b", int'(curLevel), 3);
    pulseRet(); check("R6 pop c", int'(curLevel), 2);
    pulseRet(); check("R6 pop d", int'(curLevel), 1);
    pulseRet(); check("R6 oldest lost", int'(curLevel), 1);
  endtask

  // R7 forced levels
  task automatic t_force();
    applyReset();
    pulseEnAll();   check("R7 enable", int'(curLevel), 0);
    pulseMaskAll(); check("R7 mask", int'(curLevel), 3);
    pulseEnAll();   check("R7 enable again", int'(curLevel), 0);
    enableAll = 1; maskAll = 1; @(negedge clk); enableAll = 0; maskAll = 0;
    check("R7 both", int'(curLevel), 3);
  endtask

  // R8 trap
  task automatic t_trap();
    applyReset();
    pulseEnAll();
    setLvl(0, 3);
    pulseReq(5'b00001);
    expectAck("R8 setup", 0, 4);
    pulseTrap();
    expectAck("R8 trap at level 3", 5, 4);
    check("R8 level", int'(curLevel), 3);
    applyReset();
    pulseEnAll();
    setLvl(0, 3);
    srcReq = 5'b00001; trapReq = 1; @(negedge clk); srcReq = '0; trapReq = 0;
    expectAck("R8 trap first", 5, 4);
    pulseRet();
    expectAck("R8 source after", 0, 4);
  endtask

  // R9 single service, R14 pulse width
  task automatic t_single();
    applyReset();
    nestedMode = 1;
    pulseEnAll();
    setLvl(3, 2);
    pulseReq(5'b01000);
    expectAck("R14 grant", 3, 4);
    @(negedge clk);
    check("R14 one cycle", int'(ackValid), 0);
    pulseRet();
    expectNoAck("R9 one grant per pulse", 5);
  endtask

  // R10 clear sequence
  task automatic t_clear();
    applyReset();
    setLvl(1, 2);
    pulseReq(5'b00010);
    pulseClrDat(5'b00010);
    pulseEnAll();
    expectAck("R10 data alone", 1, 4);
    applyReset();
    setLvl(1, 2);
    pulseReq(5'b00010);
    pulseClrSt(5'b00010);
    pulseClrDat(5'b00010);
    pulseEnAll();
    expectNoAck("R10 cleared", 5);
  endtask

  // R11 light sleep
  task automatic t_wait();
    bit woke = 0;
    applyReset();
    pulseEnAll();
    pulseWait();
    check("R11 asleep", int'(sleeping), 1);
    expectNoAck("R11 idle asleep", 3);
    setLvl(2, 1);
    pulseReq(5'b00100);
    for (int c = 0; c < 4 && !woke; c++) begin
      if (wakeUp) woke = 1; else @(negedge clk);
    end
    check("R11 wake pulse", int'(woke), 1);
    check("R11 running", int'(sleeping), 0);
    expectAck("R11 grant after wake", 2, 4);
  endtask

  // R12 deep-sleep filter, R13 first grant after deep sleep
  task automatic t_halt();
    applyReset();
    nestedMode = 1;
    pulseEnAll();
    haltCapable = 5'b10000;
    setLvl(0, 3); setLvl(4, 1);
    pulseHalt();
    pulseReq(5'b00001);
    expectNoAck("R12 non-capable", 5);
    check("R12 still asleep", int'(sleeping), 1);
    pulseReq(5'b10000);
    expectAck("R13 capable first", 4, 5);
    expectAck("R13 higher next", 0, 3);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset_and_gate();
    t_priority();
    t_concurrent();
    t_nested();
    t_stack();
    t_force();
    t_trap();
    t_single();
    t_clear();
    t_wait();
    t_halt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule